// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This unit manages two independent 8-bit stack pointers over a memory addressed in 4-bit nibbles. The word stack holds 16-bit values, such as return addresses and index registers. Each value takes a four-nibble slot, and the slot's lowest nibble address is the pointer times four. The nibble stack holds single 4-bit values, such as the flag register. The block creates the memory addresses, read and write strobes and write data. It runs the multi-cycle sequences for word pushes and pops, and it chains a nibble push and a word push for interrupt entry.

After reset the unit also decides whether an interrupt may be taken. It refuses every request, non-maskable ones included, until software has loaded both pointers. After that it refuses while a pointer-load pair is half done, and while a stack sequence is running. Instruction decode and the interrupt vector lie outside the block. The core issues one operation code at a time and stalls on `busy`.

The sequencer has five states. `ST_IDLE` accepts operations. `ST_NIB_WR` writes one nibble to the nibble stack. `ST_NIB_RD` reads one nibble from it. `ST_WORD_WR` writes the four nibbles of a word slot. `ST_WORD_RD` reads the four nibbles of a word slot.

The transitions are:
- `ST_IDLE` goes to `ST_WORD_WR` on a word push.
- `ST_IDLE` goes to `ST_WORD_RD` on a word pop.
- `ST_IDLE` goes to `ST_NIB_WR` on a nibble push or an interrupt entry.
- `ST_IDLE` goes to `ST_NIB_RD` on a nibble pop.
- `ST_NIB_WR` goes to `ST_WORD_WR` during interrupt entry, and otherwise back to `ST_IDLE`.
- `ST_NIB_RD` returns to `ST_IDLE`.
- `ST_WORD_WR` and `ST_WORD_RD` return to `ST_IDLE` after their fourth nibble.
- Pointer loads and the no-op complete in `ST_IDLE`.

Top module: `dstack_unit`

## Requirements
- R1: After reset both pointers read 0, `busy`, `mem_we`, `mem_re`, `pop_valid` and `irq_grant` are 0.
- R2: A word push (code 1) is accepted in an idle cycle. At that edge the word pointer P drops by one. In each of the next four cycles `busy` is 1 and one nibble k (k = 0..3) is written at address P×4+k (P being the new value), with data bits [4k+3:4k] of the word, so the least significant nibble sits lowest.
- R3: A word pop (code 2) reads four cycles at P×4+k, k = 0..3. At the last edge P rises by one, and `pop_valid` is 1 for one cycle with the reassembled 16-bit word on `pop_data`.
- R4: A nibble push (code 3) lowers the nibble pointer Q by one when accepted. In the next cycle it writes the nibble at address Q, zero-extended.
- R5: A nibble pop (code 4) reads address Q for one cycle, then raises Q by one. It pulses `pop_valid` with the nibble in `pop_data[3:0]` and zeros above.
- R6: Pointer steps wrap within 8 bits: 0 minus 1 gives 0xFF, and 0xFF plus 1 gives 0. Word slots stay inside nibble addresses 0x000 to 0x3FF.
- R7: Interrupt entry (code 5) first pushes `nib_in` (the flag nibble) onto the nibble stack, then pushes `word_in` (the return address) onto the word stack. This takes five memory cycles in that order.
- R8: `irq_grant` stays 0, even for `nmi_req`, until both the word pointer load (code 6) and the nibble pointer load (code 7) have each been accepted at least once since reset.
- R9: Once a pointer load is accepted as the first of a pair, `irq_grant` stays 0 until the next operation is accepted. A load accepted directly after a first load completes the pair.
- R10: Once armed, `irq_grant` is 1 only while the unit is idle. `nmi_req` is granted regardless of `irq_en`; `irq_req` is granted only when `irq_en` is 1.
- R11: An operation presented while `busy` is 1 is ignored: it changes neither pointer nor the sequence under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 3 | 0 none, 1 word push, 2 word pop, 3 nibble push, 4 nibble pop, 5 entry, 6 word pointer load, 7 nibble pointer load |
| word_in | input | 16 | Word to push |
| nib_in | input | 4 | Nibble to push / flag nibble |
| ptr_in | input | 8 | Value for pointer loads |
| irq_req | input | 1 | Maskable interrupt request |
| irq_en | input | 1 | Maskable interrupt enable |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mem_rdata | input | 4 | Nibble read from memory (same cycle as address) |
| mem_addr | output | 16 | Nibble address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 4 | Write nibble |
| busy | output | 1 | Sequence in progress; core must stall |
| pop_valid | output | 1 | Popped value ready |
| pop_data | output | 16 | Popped value |
| sp_word | output | 8 | Word stack pointer |
| sp_nib | output | 8 | Nibble stack pointer |
| irq_grant | output | 1 | Interrupt may be taken now |

## Verification
The hardest condition to reach from the ports is the half-finished pointer-load pair with the unit already armed. Both pointers must first have been loaded once. Then a single further load opens the window in which a pending non-maskable request must still be refused. The stimulus builds this in three steps. It arms the unit with a full pair. It issues a lone load while holding `nmi_req`. It then closes the pair and observes the grant return. Pointer wrap at both ends is reached by loading both pointers with zero, then pushing and popping across the boundary.

// File: rtl/dstack_pkg.sv
package dstack_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WPUSH = 3'd1,
        OP_WPOP  = 3'd2,
        OP_NPUSH = 3'd3,
        OP_NPOP  = 3'd4,
        OP_ENTRY = 3'd5,
        OP_LDW   = 3'd6,
        OP_LDN   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NIB_WR,
        ST_NIB_RD,
        ST_WORD_WR,
        ST_WORD_RD
    } st_e;
endpackage

// File: rtl/dstack_ptr.sv
module dstack_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (load)   q <= load_val;
        else if (inc)    q <= q + W'(1);
        else if (dec)    q <= q - W'(1);
    end

    // modulo step on the pointer field only
    assert_ptr_wrap_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !load) |=> q == $past(q) - W'(1));
    assert_ptr_wrap_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> q == $past(q) + W'(1));
endmodule

// File: rtl/dstack_gate.sv
module dstack_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic ld_word,
    input  logic ld_nib,
    input  logic idle,
    input  logic irq_req,
    input  logic irq_en,
    input  logic nmi_req,
    output logic grant
);
    logic word_set, nib_set, half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_set <= 1'b0;
            nib_set  <= 1'b0;
            half     <= 1'b0;
        end else begin
            if (ld_word) word_set <= 1'b1;
            if (ld_nib)  nib_set  <= 1'b1;
            if (accept)  half     <= (ld_word || ld_nib) && !half;
        end
    end

    assign grant = word_set && nib_set && !half && idle &&
                   (nmi_req || (irq_req && irq_en));

    assert_pair_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (ld_word || ld_nib) && !half) |=> !grant);
endmodule

// File: rtl/dstack_seq.sv
module dstack_seq
    import dstack_pkg::*;
#(
    parameter int SP_W   = 8,
    parameter int VAL_W  = 16,
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [VAL_W-1:0]  word_in,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [NIB_W-1:0]  mem_rdata,
    input  logic [SP_W-1:0]   sp_word,
    input  logic [SP_W-1:0]   sp_nib,
    output logic              accept,
    output logic              word_load,
    output logic              word_inc,
    output logic              word_dec,
    output logic              nib_load,
    output logic              nib_inc,
    output logic              nib_dec,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              busy,
    output logic              pop_valid,
    output logic [VAL_W-1:0]  pop_data
);
    localparam int NIBS  = VAL_W / NIB_W;
    localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    st_e               state, state_nx;
    op_e               op;
    logic [CNT_W-1:0]  cnt;
    logic [VAL_W-1:0]  word_q, acc;
    logic [NIB_W-1:0]  nib_q;
    logic              chain_q;

    assign op     = op_e'(op_code);
    assign accept = op_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    // pointer controls
    assign word_load = accept && (op == OP_LDW);
    assign nib_load  = accept && (op == OP_LDN);
    assign word_dec  = (accept && op == OP_WPUSH) || (state == ST_NIB_WR && chain_q);
    assign word_inc  = (state == ST_WORD_RD) && (cnt == LAST);
    assign nib_dec   = accept && (op == OP_NPUSH || op == OP_ENTRY);
    assign nib_inc   = (state == ST_NIB_RD);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_WPUSH:          state_nx = ST_WORD_WR;
                        OP_WPOP:           state_nx = ST_WORD_RD;
                        OP_NPUSH, OP_ENTRY: state_nx = ST_NIB_WR;
                        OP_NPOP:           state_nx = ST_NIB_RD;
                        default:           state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_NIB_WR:  state_nx = chain_q ? ST_WORD_WR : ST_IDLE;
            ST_NIB_RD:  state_nx = ST_IDLE;
            ST_WORD_WR: state_nx = (cnt == LAST) ? ST_IDLE : ST_WORD_WR;
            ST_WORD_RD: state_nx = (cnt == LAST) ? ST_IDLE : ST_WORD_RD;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            word_q    <= '0;
            nib_q     <= '0;
            chain_q   <= 1'b0;
            acc       <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            if (state == ST_WORD_WR || state == ST_WORD_RD) cnt <= cnt + CNT_W'(1);
            else                                          cnt <= '0;
            if (accept) begin
                word_q  <= word_in;
                nib_q   <= nib_in;
                chain_q <= (op == OP_ENTRY);
            end else if (state == ST_NIB_WR) begin
                chain_q <= 1'b0;
            end
            if (state == ST_WORD_RD) begin
                acc <= {mem_rdata, acc[VAL_W-1:NIB_W]};
                if (cnt == LAST) begin
                    pop_data  <= {mem_rdata, acc[VAL_W-1:NIB_W]};
                    pop_valid <= 1'b1;
                end
            end
            if (state == ST_NIB_RD) begin
                pop_data  <= VAL_W'(mem_rdata);
                pop_valid <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_NIB_WR: begin
                mem_addr  = ADDR_W'(sp_nib);
                mem_we    = 1'b1;
                mem_wdata = nib_q;
            end
            ST_NIB_RD: begin
                mem_addr = ADDR_W'(sp_nib);
                mem_re   = 1'b1;
            end
            ST_WORD_WR: begin
                mem_addr  = ADDR_W'({sp_word, cnt});
                mem_we    = 1'b1;
                mem_wdata = word_q[int'(cnt)*NIB_W +: NIB_W];
            end
            ST_WORD_RD: begin
                mem_addr = ADDR_W'({sp_word, cnt});
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end

    assert_no_rw_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    assert_word_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WORD_WR && cnt != '0) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
    assert_pop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);
endmodule

// File: rtl/dstack_unit.sv
module dstack_unit #(
    parameter int SP_W   = 8,
    parameter int VAL_W  = 16,
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [VAL_W-1:0]  word_in,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [SP_W-1:0]   ptr_in,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic              nmi_req,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              busy,
    output logic              pop_valid,
    output logic [VAL_W-1:0]  pop_data,
    output logic [SP_W-1:0]   sp_word,
    output logic [SP_W-1:0]   sp_nib,
    output logic              irq_grant
);
    logic accept, w_load, w_inc, w_dec, n_load, n_inc, n_dec;

    dstack_seq #(.SP_W(SP_W), .VAL_W(VAL_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .word_in(word_in), .nib_in(nib_in), .mem_rdata(mem_rdata),
        .sp_word(sp_word), .sp_nib(sp_nib), .accept(accept),
        .word_load(w_load), .word_inc(w_inc), .word_dec(w_dec),
        .nib_load(n_load), .nib_inc(n_inc), .nib_dec(n_dec),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .busy(busy), .pop_valid(pop_valid), .pop_data(pop_data)
    );

    dstack_ptr #(.W(SP_W)) u_word_ptr (
        .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(ptr_in),
        .inc(w_inc), .dec(w_dec), .q(sp_word)
    );

    dstack_ptr #(.W(SP_W)) u_nib_ptr (
        .clk(clk), .rst_n(rst_n), .load(n_load), .load_val(ptr_in),
        .inc(n_inc), .dec(n_dec), .q(sp_nib)
    );

    dstack_gate u_gate (
        .clk(clk), .rst_n(rst_n), .accept(accept), .ld_word(w_load), .ld_nib(n_load),
        .idle(!busy), .irq_req(irq_req), .irq_en(irq_en), .nmi_req(nmi_req),
        .grant(irq_grant)
    );

    assert_grant_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |-> !mem_we && !mem_re);
endmodule

// File: tb/sim_dstack_unit.sv
`timescale 1ns/100ps
module sim_dstack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] word_in = '0;
    logic [3:0]  nib_in = '0;
    logic [7:0]  ptr_in = '0;
    logic        irq_req = 1'b0, irq_en = 1'b0, nmi_req = 1'b0;
    logic [3:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re, busy, pop_valid, irq_grant;
    logic [3:0]  mem_wdata;
    logic [15:0] pop_data;
    logic [7:0]  sp_word, sp_nib;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] bmem [0:1023];

    always #2.5 clk = ~clk;

    dstack_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .word_in(word_in), .nib_in(nib_in), .ptr_in(ptr_in),
        .irq_req(irq_req), .irq_en(irq_en), .nmi_req(nmi_req),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .busy(busy), .pop_valid(pop_valid), .pop_data(pop_data),
        .sp_word(sp_word), .sp_nib(sp_nib), .irq_grant(irq_grant)
    );

    assign mem_rdata = bmem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] w,
                          input logic [3:0] n, input logic [7:0] p);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; word_in = w; nib_in = n; ptr_in = p;
        @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // op[39:37] word[36:21] nib[20:17] expected[16:1] check[0]
    localparam int NV = 8;
    localparam logic [39:0] TBL [NV] = '{
        {3'd1, 16'h1234, 4'h0, 16'h0000, 1'b0},
        {3'd3, 16'h0000, 4'hA, 16'h0000, 1'b0},
        {3'd1, 16'hF00D, 4'h0, 16'h0000, 1'b0},
        {3'd3, 16'h0000, 4'h5, 16'h0000, 1'b0},
        {3'd4, 16'h0000, 4'h0, 16'h0005, 1'b1},
        {3'd2, 16'h0000, 4'h0, 16'hF00D, 1'b1},
        {3'd2, 16'h0000, 4'h0, 16'h1234, 1'b1},
        {3'd4, 16'h0000, 4'h0, 16'h000A, 1'b1}
    };

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 4'h0;
        nmi_req = 1'b1; irq_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp_word", sp_word, 0);
        chk("R1 sp_nib", sp_nib, 0);
        chk("R1 busy", busy, 0);
        chk("R1 we/re", {mem_we, mem_re}, 0);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R8 grant before loads", irq_grant, 0);

        // R8: one load only keeps grant off
        run_op(3'd6, 16'h0, 4'h0, 8'h10);
        chk("R8 grant after word load only", irq_grant, 0);
        run_op(3'd7, 16'h0, 4'h0, 8'h80);
        chk("R8 grant after both loads", irq_grant, 1);
        chk("R8 sp_word loaded", sp_word, 8'h10);
        chk("R8 sp_nib loaded", sp_nib, 8'h80);

        // R10 masking
        nmi_req = 1'b0; irq_req = 1'b1; irq_en = 1'b0;
        @(negedge clk);
        chk("R10 maskable disabled", irq_grant, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 maskable enabled", irq_grant, 1);
        irq_req = 1'b0; nmi_req = 1'b1;

        // R9: half pair holds off nmi
        run_op(3'd6, 16'h0, 4'h0, 8'h10);
        chk("R9 grant during half pair", irq_grant, 0);
        run_op(3'd7, 16'h0, 4'h0, 8'h80);
        chk("R9 grant after pair done", irq_grant, 1);

        // R2 cycle by cycle word push of 0xBEEF
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; word_in = 16'hBEEF;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 sp_word after accept", sp_word, 8'h0F);
        chk("R10 grant while busy", irq_grant, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R2 busy", busy, 1);
            chk("R2 we", mem_we, 1);
            chk("R2 addr", mem_addr, 16'h003C + 16'(k));
            chk("R2 wdata", mem_wdata, (32'hBEEF >> (4*k)) & 32'hF);
            @(negedge clk);
        end
        chk("R2 busy done", busy, 0);

        // R3 cycle by cycle pop
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2;
        @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R3 re", mem_re, 1);
            chk("R3 addr", mem_addr, 16'h003C + 16'(k));
            @(negedge clk);
        end
        chk("R3 pop_valid", pop_valid, 1);
        chk("R3 pop_data", pop_data, 16'hBEEF);
        chk("R3 sp_word restored", sp_word, 8'h10);
        @(negedge clk);
        chk("R3 pop_valid single", pop_valid, 0);

        // table-driven LIFO mix
        for (int v = 0; v < NV; v++) begin
            run_op(TBL[v][39:37], TBL[v][36:21], TBL[v][20:17], 8'h00);
            if (TBL[v][0]) begin
                chk((TBL[v][39:37] == 3'd2) ? "R3 table pop_valid" : "R5 table pop_valid",
                    pop_valid, 1);
                chk((TBL[v][39:37] == 3'd2) ? "R3 table pop_data" : "R5 table pop_data",
                    pop_data, TBL[v][16:1]);
            end
        end
        chk("R4 nibble slot", bmem[10'h07F], 4'hA);
        chk("R2 sp_word balanced", sp_word, 8'h10);
        chk("R5 sp_nib balanced", sp_nib, 8'h80);

        // R7 interrupt entry
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd5; word_in = 16'h4321; nib_in = 4'h9;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 flag first addr", mem_addr, 16'h007F);
        chk("R7 flag first data", {mem_we, mem_wdata}, {1'b1, 4'h9});
        @(negedge clk);
        chk("R7 sp_word dec", sp_word, 8'h0F);
        chk("R7 word addr", mem_addr, 16'h003C);
        chk("R7 word nib0", mem_wdata, 4'h1);
        while (busy) @(negedge clk);
        chk("R7 slot", {bmem[10'h03F], bmem[10'h03E], bmem[10'h03D], bmem[10'h03C]}, 16'h4321);
        run_op(3'd2, 16'h0, 4'h0, 8'h0);
        chk("R7 return addr popped", pop_data, 16'h4321);
        run_op(3'd4, 16'h0, 4'h0, 8'h0);
        chk("R7 flag popped", pop_data, 16'h0009);

        // R11 op while busy ignored
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; word_in = 16'h7777;
        @(negedge clk);
        op_code = 3'd6; ptr_in = 8'h55;
        @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R11 sp_word unchanged by busy load", sp_word, 8'h0F);
        chk("R11 slot intact", {bmem[10'h03F], bmem[10'h03E], bmem[10'h03D], bmem[10'h03C]}, 16'h7777);
        run_op(3'd2, 16'h0, 4'h0, 8'h0);

        // R6 wrap at both ends
        run_op(3'd6, 16'h0, 4'h0, 8'h00);
        run_op(3'd7, 16'h0, 4'h0, 8'h00);
        run_op(3'd3, 16'h0, 4'h3, 8'h00);
        chk("R6 sp_nib wrap down", sp_nib, 8'hFF);
        chk("R6 nibble at top", bmem[10'h0FF], 4'h3);
        run_op(3'd1, 16'hABCD, 4'h0, 8'h00);
        chk("R6 sp_word wrap down", sp_word, 8'hFF);
        chk("R6 top slot", {bmem[10'h3FF], bmem[10'h3FE], bmem[10'h3FD], bmem[10'h3FC]}, 16'hABCD);
        run_op(3'd2, 16'h0, 4'h0, 8'h00);
        chk("R6 pop at top", pop_data, 16'hABCD);
        chk("R6 sp_word wrap up", sp_word, 8'h00);
        run_op(3'd4, 16'h0, 4'h0, 8'h00);
        chk("R6 nibble pop at top", pop_data, 16'h0003);
        chk("R6 sp_nib wrap up", sp_nib, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule